// File: doc/BRIEF.md
# Saturating Element Clamp Stage

This block sits at the end of a vector integer datapath and post-processes one result element per clock. It receives the exact intermediate result of an element operation as a 65-bit two's-complement value, together with the source and destination element widths, a signed/unsigned select and a saturate enable. It first limits the intermediate to the width the operation was carried out at, then clamps it to the range of the destination element width (or, with saturation off, simply truncates it). The result leaves in the low bits of a 64-bit output.

Alongside the result, each element gets its own 4-bit condition field. It reports whether the stored value is below, above or equal to zero, and whether clamping took place. The clamp flag reflects only this element: any sticky summary-overflow state that travels with the instruction is disregarded. An instruction that asks for saturation and also requests overflow recording is flagged as illegal, because both would claim the same condition bit. All outputs are registered, so the stage adds exactly one cycle of latency and has no handshake.

Top module: `sat_elem_clamp`

## Requirements
- R1: With `signed_sel`=0 and `sat_en`=1, a value above 2^n-1 yields 2^n-1 and a value below 0 yields 0, where n is the destination width. Widths are coded 0=8, 1=16, 2=32, 3=64 bits. The result occupies bits n-1:0 of `res_out`, and the bits above are zero.
- R2: With `signed_sel`=1 and `sat_en`=1, the value is clamped to the range -2^(n-1) to 2^(n-1)-1. It is output as an n-bit two's-complement pattern in bits n-1:0, and the bits above are zero.
- R3: The operation width is the larger of `src_w` and `dst_w`, with m bits. Before clamping, the intermediate keeps its low min(m+2,65) bits and is sign-extended from the top kept bit.
- R4: With `rec_en`=1 and `sat_en`=1, the so bit (`cond_out[0]`) is 1 exactly when the value was changed by clamping.
- R5: `so_sticky` has no effect on any output.
- R6: `illegal_out` is 1 exactly when `sat_en` and `oe_en` were both 1 on the input cycle.
- R7: With `rec_en`=1, `cond_out[3]` (lt), `cond_out[2]` (gt) and `cond_out[1]` (eq) describe the stored n-bit result compared with zero. The result is read as signed when `signed_sel`=1 and as unsigned otherwise, so exactly one of the three bits is set.
- R8: With `sat_en`=0, the result is the low n bits of the operation-width value and so is 0.
- R9: With `rec_en`=0, `cond_out` is all zero.
- R10: Outputs reflect the inputs of the previous clock edge. A synchronous active-high `rst` clears `res_out`, `cond_out` and `illegal_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_in | input | 65 | Exact intermediate result, two's complement |
| src_w | input | 2 | Source element width code |
| dst_w | input | 2 | Destination element width code |
| signed_sel | input | 1 | 1 = signed clamp and compare, 0 = unsigned |
| sat_en | input | 1 | Saturation enable |
| oe_en | input | 1 | Overflow-recording request of the instruction |
| rec_en | input | 1 | Condition-field recording enable |
| so_sticky | input | 1 | Sticky summary-overflow state (disregarded) |
| res_out | output | 64 | Clamped or truncated element result |
| cond_out | output | 4 | Condition field {lt, gt, eq, so} |
| illegal_out | output | 1 | Forbidden saturate plus overflow-record combination |

## Verification
On every cycle, the assertions check the following relations. The eq flag agrees with a zero result, at most one compare flag is set (exactly one when recording is on), and a disabled record gives an empty field. The so bit never appears without saturation or from the sticky input alone. The illegal flag follows the saturate and overflow-request pair, and an unsigned byte result never spills above bit 7. The exact clamp limits, the choice of operation width from the two element widths, the signed and unsigned compare readings, the truncation values, and the one-cycle timing against mid-run reset can be shown only by the bench's directed scenarios with known expected values.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } elw_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    localparam int unsigned GUARD_BITS = 2;

    function automatic int unsigned ew_bits(elw_e w);
        return 32'd8 << int'(w);
    endfunction

    function automatic elw_e ew_max(elw_e a, elw_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sat_opwidth_wrap.sv
module sat_opwidth_wrap
    import sat_clamp_pkg::*;
#(
    parameter int unsigned IW = 65
) (
    input  logic signed [IW-1:0] x_in,
    input  elw_e                 src_w,
    input  elw_e                 dst_w,
    output logic signed [IW-1:0] x_out
);
    int unsigned          op_n;
    int unsigned          keep;
    int unsigned          sh;
    logic signed [IW-1:0] up;

    always_comb begin
        op_n  = ew_bits(ew_max(src_w, dst_w));
        keep  = (op_n + GUARD_BITS > IW) ? IW : op_n + GUARD_BITS;
        sh    = IW - keep;
        up    = x_in <<< sh;
        x_out = up >>> sh;
    end
endmodule

// File: rtl/sat_range_clamp.sv
module sat_range_clamp
    import sat_clamp_pkg::*;
#(
    parameter int unsigned IW = 65,
    parameter int unsigned RW = 64
) (
    input  logic signed [IW-1:0] v_in,
    input  elw_e                 dst_w,
    input  logic                 signed_sel,
    input  logic                 sat_en,
    output logic [RW-1:0]        res,
    output logic                 hit
);
    int unsigned          n;
    logic [IW-1:0]        mask_n;
    logic signed [IW-1:0] hi;
    logic signed [IW-1:0] lo;
    logic signed [IW-1:0] c;

    always_comb begin
        n      = ew_bits(dst_w);
        mask_n = (IW'(1) << n) - IW'(1);
        if (signed_sel) begin
            hi = signed'(mask_n >> 1);
            lo = ~hi;
        end else begin
            hi = signed'(mask_n);
            lo = '0;
        end
        hit = 1'b0;
        c   = v_in;
        if (sat_en && (v_in > hi)) begin
            c   = hi;
            hit = 1'b1;
        end else if (sat_en && (v_in < lo)) begin
            c   = lo;
            hit = 1'b1;
        end
        res = RW'(c & signed'(mask_n));
    end
endmodule

// File: rtl/sat_cond_gen.sv
module sat_cond_gen
    import sat_clamp_pkg::*;
#(
    parameter int unsigned RW = 64
) (
    input  logic [RW-1:0] r,
    input  elw_e          dst_w,
    input  logic          signed_sel,
    input  logic          hit,
    input  logic          rec_en,
    output cond_t         cond
);
    int unsigned n;
    logic        neg;
    logic        zero;

    always_comb begin
        n    = ew_bits(dst_w);
        neg  = signed_sel & r[n-1];
        zero = (r == '0);
        if (rec_en) begin
            cond.lt = neg;
            cond.gt = !neg && !zero;
            cond.eq = zero;
            cond.so = hit;
        end else begin
            cond = '0;
        end
    end
endmodule

// File: rtl/sat_elem_clamp.sv
module sat_elem_clamp
    import sat_clamp_pkg::*;
#(
    parameter int unsigned RW = 64,
    localparam int unsigned IW = RW + 1,
    localparam int unsigned CW = $bits(cond_t)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IW-1:0] res_in,
    input  logic [1:0]           src_w,
    input  logic [1:0]           dst_w,
    input  logic                 signed_sel,
    input  logic                 sat_en,
    input  logic                 oe_en,
    input  logic                 rec_en,
    input  logic                 so_sticky,
    output logic [RW-1:0]        res_out,
    output logic [CW-1:0]        cond_out,
    output logic                 illegal_out
);
    elw_e                 src_e;
    elw_e                 dst_e;
    logic signed [IW-1:0] wrapped;
    logic [RW-1:0]        clamped;
    logic                 hit;
    cond_t                cond_d;
    cond_t                cond_q;
    logic [RW-1:0]        res_q;
    logic                 illegal_q;

    assign src_e = elw_e'(src_w);
    assign dst_e = elw_e'(dst_w);

    sat_opwidth_wrap #(.IW(IW)) i_wrap (
        .x_in  (res_in),
        .src_w (src_e),
        .dst_w (dst_e),
        .x_out (wrapped)
    );

    sat_range_clamp #(.IW(IW), .RW(RW)) i_clamp (
        .v_in       (wrapped),
        .dst_w      (dst_e),
        .signed_sel (signed_sel),
        .sat_en     (sat_en),
        .res        (clamped),
        .hit        (hit)
    );

    sat_cond_gen #(.RW(RW)) i_cond (
        .r          (clamped),
        .dst_w      (dst_e),
        .signed_sel (signed_sel),
        .hit        (hit),
        .rec_en     (rec_en),
        .cond       (cond_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            cond_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            res_q     <= clamped;
            cond_q    <= cond_d;
            illegal_q <= sat_en & oe_en;
        end
    end

    assign res_out     = res_q;
    assign cond_out    = cond_q;
    assign illegal_out = illegal_q;

    // R7
    eq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cond_q.eq |-> (res_q == '0));

    // R7
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && rec_en) |-> ($countones({cond_q.lt, cond_q.gt, cond_q.eq}) == 1));

    // R9
    norec_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !rec_en) |-> (cond_q == '0));

    // R4
    so_src_chk: assert property (@(posedge clk) disable iff (rst)
        cond_q.so |-> $past(sat_en && rec_en));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && so_sticky && !sat_en) |-> !cond_q.so);

    // R6
    illegal_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (illegal_q == $past(sat_en && oe_en)));

    // R1
    ubyte_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !signed_sel && sat_en && dst_w == 2'd0) |-> (res_q[RW-1:8] == '0));

endmodule

// File: tb/test_sat_elem_clamp.sv
module test_sat_elem_clamp;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [64:0] res_in = '0;
    logic [1:0]         src_w = '0;
    logic [1:0]         dst_w = '0;
    logic               signed_sel = 1'b0;
    logic               sat_en = 1'b0;
    logic               oe_en = 1'b0;
    logic               rec_en = 1'b0;
    logic               so_sticky = 1'b0;
    logic [63:0]        res_out;
    logic [3:0]         cond_out;
    logic               illegal_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sat_elem_clamp i_sat_elem_clamp (
        .clk, .rst, .res_in, .src_w, .dst_w, .signed_sel, .sat_en,
        .oe_en, .rec_en, .so_sticky, .res_out, .cond_out, .illegal_out
    );

    task automatic check(input string tag, input logic [63:0] er,
                         input logic [3:0] ec, input logic ei);
        n_run++;
        if (res_out !== er || cond_out !== ec || illegal_out !== ei) begin
            n_fail++;
            $display("FAIL %s: res=%h cond=%b ill=%b expected res=%h cond=%b ill=%b",
                     tag, res_out, cond_out, illegal_out, er, ec, ei);
        end
    endtask

    task automatic apply(input logic signed [64:0] v, input logic [1:0] sw,
                         input logic [1:0] dw, input logic sg, input logic sat,
                         input logic oe, input logic rec, input logic stk);
        @(negedge clk);
        res_in = v; src_w = sw; dst_w = dw; signed_sel = sg;
        sat_en = sat; oe_en = oe; rec_en = rec; so_sticky = stk;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 reset state", 64'h0, 4'b0000, 1'b0);
    endtask

    task automatic t_unsigned();
        apply(65'sd300, 2'd0, 2'd0, 0, 1, 0, 1, 0);
        check("R1 R4 u8 high clamp", 64'hFF, 4'b0101, 0);
        apply(-65'sd5, 2'd1, 2'd1, 0, 1, 0, 1, 0);
        check("R1 R4 u16 low clamp", 64'h0, 4'b0011, 0);
        apply(65'sd1000, 2'd1, 2'd1, 0, 1, 0, 1, 0);
        check("R1 R4 u16 in range", 64'd1000, 4'b0100, 0);
        apply(-65'sd1, 2'd3, 2'd3, 0, 1, 0, 1, 0);
        check("R1 u64 negative", 64'h0, 4'b0011, 0);
        apply(65'h0_FFFF_FFFF_FFFF_FFFF, 2'd3, 2'd3, 0, 1, 0, 1, 0);
        check("R1 R7 u64 max kept", 64'hFFFF_FFFF_FFFF_FFFF, 4'b0100, 0);
    endtask

    task automatic t_signed();
        apply(65'sd200, 2'd0, 2'd0, 1, 1, 0, 1, 0);
        check("R2 s8 high clamp", 64'h7F, 4'b0101, 0);
        apply(-65'sd200, 2'd0, 2'd0, 1, 1, 0, 1, 0);
        check("R2 R7 s8 low clamp", 64'h80, 4'b1001, 0);
        apply(-65'sd7, 2'd2, 2'd2, 1, 1, 0, 1, 0);
        check("R2 R7 s32 negative", 64'hFFFF_FFF9, 4'b1000, 0);
        apply(65'sd0, 2'd1, 2'd1, 1, 1, 0, 1, 0);
        check("R7 s16 zero", 64'h0, 4'b0010, 0);
        apply(65'h0_8000_0000_0000_0000, 2'd3, 2'd3, 1, 1, 0, 1, 0);
        check("R2 s64 high clamp", 64'h7FFF_FFFF_FFFF_FFFF, 4'b0101, 0);
    endtask

    task automatic t_opwidth();
        apply(65'sd1029, 2'd0, 2'd0, 0, 1, 0, 1, 0);
        check("R3 op width 8 drops high bits", 64'd5, 4'b0100, 0);
        apply(65'sd1029, 2'd1, 2'd0, 0, 1, 0, 1, 0);
        check("R3 op width 16 then clamp", 64'hFF, 4'b0101, 0);
        apply(65'sd1029, 2'd0, 2'd1, 0, 1, 0, 1, 0);
        check("R3 dst wider than src", 64'd1029, 4'b0100, 0);
    endtask

    task automatic t_nosat();
        apply(65'sd300, 2'd1, 2'd0, 0, 0, 0, 1, 0);
        check("R8 unsigned truncate", 64'h2C, 4'b0100, 0);
        apply(65'sd511, 2'd0, 2'd0, 1, 0, 0, 1, 0);
        check("R8 R7 signed truncate", 64'hFF, 4'b1000, 0);
    endtask

    task automatic t_sticky();
        apply(65'sd10, 2'd0, 2'd0, 0, 1, 0, 1, 1);
        check("R5 sticky with sat in range", 64'd10, 4'b0100, 0);
        apply(65'sd10, 2'd0, 2'd0, 0, 0, 0, 1, 1);
        check("R5 sticky with sat off", 64'd10, 4'b0100, 0);
    endtask

    task automatic t_illegal();
        apply(65'sd10, 2'd0, 2'd0, 0, 1, 1, 1, 0);
        check("R6 sat with oe", 64'd10, 4'b0100, 1);
        apply(65'sd10, 2'd0, 2'd0, 0, 0, 1, 1, 0);
        check("R6 oe alone", 64'd10, 4'b0100, 0);
        apply(65'sd10, 2'd0, 2'd0, 0, 1, 0, 1, 0);
        check("R6 sat alone", 64'd10, 4'b0100, 0);
    endtask

    task automatic t_norec();
        apply(65'sd300, 2'd0, 2'd0, 0, 1, 0, 0, 0);
        check("R9 no record clamped", 64'hFF, 4'b0000, 0);
    endtask

    task automatic t_timing();
        apply(65'sd7, 2'd0, 2'd0, 0, 1, 0, 1, 0);
        check("R10 first value", 64'd7, 4'b0100, 0);
        @(negedge clk);
        res_in = 65'sd9;
        #1;
        check("R10 holds before edge", 64'd7, 4'b0100, 0);
        @(negedge clk);
        check("R10 next value after edge", 64'd9, 4'b0100, 0);
        oe_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", 64'h0, 4'b0000, 0);
        rst = 1'b0;
        oe_en = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_unsigned();
        t_signed();
        t_opwidth();
        t_nosat();
        t_sticky();
        t_illegal();
        t_norec();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule